// File: doc/BRIEF.md
# Instruction Field Splitter

This block takes a variable-length instruction as a stream of bytes, one byte per clock, and breaks it into its fields. The fields are the prefix bytes, a one- or two-byte opcode, the operand-form byte (ModR/M), the scaled-index byte (SIB), the displacement and the immediate. It reports the prefix flags and the opcode. It splits the operand-form and scaled-index bytes into their sub-fields. It puts the displacement and the immediate together as integers and counts the total length in bytes. A mode pin gives the default operand and address size, either 16-bit or 32-bit.

A small built-in opcode table decides two things: whether an operand-form byte follows the opcode, and how wide the immediate is. The operand-form and scaled-index bytes then decide whether a displacement follows and how long it is. The block takes a new byte every cycle. It fires a one-cycle completion strobe after the last byte of each instruction and is at once ready for the next one.

Top module: `insnFieldParser`

## Requirements
- R1: `inReady` is high from the first clock after reset. A byte is taken on a cycle with `inValid` and `inReady` both high. `outDone` is high for exactly the one cycle after the last byte of an instruction is taken and stays low after every earlier byte.
- R2: Before the opcode, up to four prefix bytes are taken, in any order and with repeats. F0h sets `outLock`, F2h sets `outRepNe`, F3h sets `outRep`, 66h sets `outOpSzOvr` and 67h sets `outAdSzOvr`. A segment prefix sets `outSegValid` and writes `outSegCode`: 26h→0, 2Eh→1, 36h→2, 3Eh→3, 64h→4, 65h→5. When there are several segment prefixes, the last one wins.
- R3: A fifth prefix byte ends the instruction with `outDone` and `outError` high and a length of 5.
- R4: A first opcode byte of 0Fh takes one more opcode byte. Then `outOpcode` = {0Fh, second byte} and `outTwoByte` = 1. Otherwise `outOpcode` = {00h, byte} and `outTwoByte` = 0.
- R5: An opcode missing from the table ends the instruction with `outError` high. The length counts every byte taken, including the opcode.
- R6: For table opcodes that carry it, the operand-form byte is taken and split into mod (bits 7:6), reg (bits 5:3) and r/m (bits 2:0), with `outHasModrm` = 1.
- R7: A scaled-index byte follows only when the effective address size is 32 bits, r/m = 100 and mod ≠ 11. It is split into scale (bits 7:6), index (bits 5:3) and base (bits 2:0).
- R8: The displacement length depends on mod. mod = 01 gives 1 byte. mod = 10 gives 4 bytes at 32-bit address size and 2 bytes at 16-bit address size. mod = 11 gives none. mod = 00 gives 4 bytes at 32-bit size with r/m = 101, 2 bytes at 16-bit size with r/m = 110, and none otherwise.
- R9: With mod = 00 and a scaled-index base field of 101, a 4-byte displacement follows.
- R10: Displacement and immediate bytes arrive low byte first. They are put together zero-extended into 32 bits and read 0 when absent.
- R11: The immediate is 0 or 1 byte, or word-sized by opcode. Word-sized means 4 bytes at 32-bit operand size and 2 bytes at 16-bit operand size.
- R12: `outAddr32` = `mode32` XOR the 67h flag and `outOp32` = `mode32` XOR the 66h flag. These give the sizes used for the displacement and the immediate.
- R13: `outLen` equals the number of bytes taken for the instruction.
- R14: The first byte of the next instruction may be taken in the `outDone` cycle. All fields then restart from zero, with no trace of the earlier instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte on `inByte` is valid |
| inByte | input | 8 | Instruction stream byte |
| inReady | output | 1 | Block accepts a byte |
| mode32 | input | 1 | Default size: 1 = 32-bit, 0 = 16-bit |
| outDone | output | 1 | Instruction complete (one cycle) |
| outError | output | 1 | Instruction ended on an error |
| outLen | output | LEN_W | Instruction length in bytes |
| outLock | output | 1 | F0h seen |
| outRepNe | output | 1 | F2h seen |
| outRep | output | 1 | F3h seen |
| outSegValid | output | 1 | Segment prefix seen |
| outSegCode | output | 3 | Segment prefix code |
| outOpSzOvr | output | 1 | 66h seen |
| outAdSzOvr | output | 1 | 67h seen |
| outOp32 | output | 1 | Effective operand size is 32 |
| outAddr32 | output | 1 | Effective address size is 32 |
| outOpcode | output | 16 | Opcode bytes |
| outTwoByte | output | 1 | Two-byte opcode |
| outHasModrm | output | 1 | Operand-form byte present |
| outMod | output | 2 | mod field |
| outReg | output | 3 | reg field |
| outRm | output | 3 | r/m field |
| outHasSib | output | 1 | Scaled-index byte present |
| outScale | output | 2 | scale field |
| outIndex | output | 3 | index field |
| outBase | output | 3 | base field |
| outDisp | output | 32 | Displacement value |
| outImm | output | 32 | Immediate value |

## Verification
Random instructions are built from random prefix mixes, opcodes drawn from the table, and random operand-form and scaled-index bytes under both modes. Each one tells apart every pairing of mod, r/m, address size and operand size that changes how many bytes follow. Random idle gaps between bytes show that only accepted bytes move the parse along. Directed streams pick out the corner cases: an encoded 32-bit memory operand reached through both override prefixes in 16-bit mode, the special mod = 00 displacement forms, and a scaled-index form attempted at 16-bit address size. Two error endings are covered, a fifth prefix and an opcode outside the table. Single-byte instructions sent back to back show that fields restart cleanly.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

  typedef enum logic [1:0] {IMM_NONE, IMM_BYTE, IMM_WORD} immKind_e;

  typedef struct packed {
    logic     known;
    logic     needModrm;
    immKind_e imm;
  } opInfo_t;

  typedef enum logic [2:0] {ST_PFX, ST_OP2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clr;
    logic       ldPfx;
    logic       ldOp1;
    logic       ldOp2;
    logic       ldModrm;
    logic       ldSib;
    logic       ldDisp;
    logic       ldImm;
    logic [1:0] idx;
  } strobe_t;

  function automatic logic isPrefix(input logic [7:0] b);
    case (b)
      8'hF0, 8'hF2, 8'hF3, 8'h66, 8'h67,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic opInfo_t lookupOne(input logic [7:0] op);
    opInfo_t r;
    r = '{1'b0, 1'b0, IMM_NONE};
    if (op[7:6] == 2'b00) begin
      if (!op[2])                r = '{1'b1, 1'b1, IMM_NONE};
      else if (op[1:0] == 2'b00) r = '{1'b1, 1'b0, IMM_BYTE};
      else if (op[1:0] == 2'b01) r = '{1'b1, 1'b0, IMM_WORD};
    end else begin
      case (op) inside
        [8'h40:8'h5F], 8'h90, 8'hC3, 8'hF4:         r = '{1'b1, 1'b0, IMM_NONE};
        8'h68, 8'hE8, 8'hE9, [8'hB8:8'hBF]:         r = '{1'b1, 1'b0, IMM_WORD};
        8'h6A, 8'hEB, [8'h70:8'h7F], [8'hB0:8'hB7]: r = '{1'b1, 1'b0, IMM_BYTE};
        8'h80, 8'h83, 8'hC6:                        r = '{1'b1, 1'b1, IMM_BYTE};
        8'h81, 8'hC7:                               r = '{1'b1, 1'b1, IMM_WORD};
        [8'h88:8'h8B], 8'h8D:                       r = '{1'b1, 1'b1, IMM_NONE};
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic opInfo_t lookupTwo(input logic [7:0] op);
    opInfo_t r;
    r = '{1'b0, 1'b0, IMM_NONE};
    case (op) inside
      [8'h80:8'h8F]:                    r = '{1'b1, 1'b0, IMM_WORD};
      8'hAF, 8'hB6, 8'hB7, 8'hBE, 8'hBF: r = '{1'b1, 1'b1, IMM_NONE};
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ifpControl.sv
module ifpControl
  import ifp_pkg::*;
#(
  parameter int MAX_PREFIX = 4,
  parameter int LEN_W      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  input  logic             mode32,
  input  logic             opSzOvr,
  input  logic             adSzOvr,
  output logic             inReady,
  output strobe_t          stb,
  output logic             outDone,
  output logic             outError,
  output logic [LEN_W-1:0] outLen
);
  localparam int PFX_W  = $clog2(MAX_PREFIX + 1);
  localparam int MAXLEN = MAX_PREFIX + 12;

  state_e           state, nState;
  logic [PFX_W-1:0] pfxCnt, nPfx;
  logic [LEN_W-1:0] lenCnt;
  logic [2:0]       immLen, nImm, dispLen, nDisp, dLen;
  logic [1:0]       byteIdx, nIdx, modHold, nMod;
  logic             readyQ, doneQ, errQ;
  logic [LEN_W-1:0] lenQ;
  logic             fire, finish, fail, useInfo, goAddr, op32, addr32;
  opInfo_t          info;

  // prefix flags in the datapath are stale until the first prefix of this insn
  assign op32   = mode32 ^ (opSzOvr && pfxCnt != '0);
  assign addr32 = mode32 ^ (adSzOvr && pfxCnt != '0);
  assign fire   = inValid && readyQ;

  always_comb begin
    stb     = '0;
    nState  = state;
    nPfx    = pfxCnt;
    nImm    = immLen;
    nDisp   = dispLen;
    nIdx    = byteIdx;
    nMod    = modHold;
    finish  = 1'b0;
    fail    = 1'b0;
    useInfo = 1'b0;
    goAddr  = 1'b0;
    dLen    = 3'd0;
    info    = '{1'b0, 1'b0, IMM_NONE};
    if (fire) begin
      stb.clr = (state == ST_PFX) && (pfxCnt == '0);
      stb.idx = byteIdx;
      case (state)
        ST_PFX: begin
          if (isPrefix(inByte)) begin
            if (pfxCnt == PFX_W'(MAX_PREFIX)) fail = 1'b1;
            else begin
              stb.ldPfx = 1'b1;
              nPfx      = pfxCnt + 1'b1;
            end
          end else begin
            stb.ldOp1 = 1'b1;
            info      = lookupOne(inByte);
            if (inByte == 8'h0F)  nState  = ST_OP2;
            else if (!info.known) fail    = 1'b1;
            else                  useInfo = 1'b1;
          end
        end
        ST_OP2: begin
          stb.ldOp2 = 1'b1;
          info      = lookupTwo(inByte);
          if (!info.known) fail = 1'b1;
          else useInfo = 1'b1;
        end
        ST_MODRM: begin
          stb.ldModrm = 1'b1;
          nMod        = inByte[7:6];
          if (addr32 && inByte[2:0] == 3'b100 && inByte[7:6] != 2'b11) nState = ST_SIB;
          else begin
            goAddr = 1'b1;
            case (inByte[7:6])
              2'b01:   dLen = 3'd1;
              2'b10:   dLen = addr32 ? 3'd4 : 3'd2;
              2'b00:   dLen = (addr32 && inByte[2:0] == 3'b101) ? 3'd4 :
                              (!addr32 && inByte[2:0] == 3'b110) ? 3'd2 : 3'd0;
              default: dLen = 3'd0;
            endcase
          end
        end
        ST_SIB: begin
          stb.ldSib = 1'b1;
          goAddr    = 1'b1;
          if (modHold == 2'b01)      dLen = 3'd1;
          else if (modHold == 2'b10) dLen = 3'd4;
          else                       dLen = (inByte[2:0] == 3'b101) ? 3'd4 : 3'd0;
        end
        ST_DISP: begin
          stb.ldDisp = 1'b1;
          if ({1'b0, byteIdx} == dispLen - 3'd1) begin
            nIdx = 2'd0;
            if (immLen != 3'd0) nState = ST_IMM;
            else finish = 1'b1;
          end else nIdx = byteIdx + 2'd1;
        end
        ST_IMM: begin
          stb.ldImm = 1'b1;
          if ({1'b0, byteIdx} == immLen - 3'd1) finish = 1'b1;
          else nIdx = byteIdx + 2'd1;
        end
        default: fail = 1'b1;
      endcase
      if (useInfo) begin
        case (info.imm)
          IMM_BYTE: nImm = 3'd1;
          IMM_WORD: nImm = op32 ? 3'd4 : 3'd2;
          default:  nImm = 3'd0;
        endcase
        if (info.needModrm)  nState = ST_MODRM;
        else if (nImm != '0) nState = ST_IMM;
        else                 finish = 1'b1;
      end
      if (goAddr) begin
        nDisp = dLen;
        if (dLen != 3'd0)        nState = ST_DISP;
        else if (immLen != 3'd0) nState = ST_IMM;
        else                     finish = 1'b1;
      end
      if (finish || fail) begin
        nState = ST_PFX;
        nPfx   = '0;
        nIdx   = 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PFX;
      pfxCnt  <= '0;
      lenCnt  <= '0;
      immLen  <= 3'd0;
      dispLen <= 3'd0;
      byteIdx <= 2'd0;
      modHold <= 2'd0;
      readyQ  <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
      lenQ    <= '0;
    end else begin
      readyQ  <= 1'b1;
      state   <= nState;
      pfxCnt  <= nPfx;
      immLen  <= nImm;
      dispLen <= nDisp;
      byteIdx <= nIdx;
      modHold <= nMod;
      doneQ   <= fire && (finish || fail);
      errQ    <= fire && fail;
      if (fire) begin
        lenCnt <= (finish || fail) ? '0 : lenCnt + LEN_W'(1);
        if (finish || fail) lenQ <= lenCnt + LEN_W'(1);
      end
    end
  end

  assign inReady  = readyQ;
  assign outDone  = doneQ;
  assign outError = errQ;
  assign outLen   = lenQ;

  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> doneQ);
  p_done_after_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(fire));
  p_prefix_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    pfxCnt <= PFX_W'(MAX_PREFIX));
  p_len_range_r13: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (lenQ != '0 && lenQ <= LEN_W'(MAXLEN)));
  p_disp_index_r10: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DISP |-> {1'b0, byteIdx} < dispLen);
  p_sib_follows_modrm_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SIB && !$stable(state)) |-> $past(state) == ST_MODRM);
endmodule

// File: rtl/ifpDatapath.sv
module ifpDatapath
  import ifp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode32,
  input  strobe_t     stb,
  input  logic [7:0]  inByte,
  output logic        lock,
  output logic        repNe,
  output logic        rep,
  output logic        segValid,
  output logic [2:0]  segCode,
  output logic        opSzOvr,
  output logic        adSzOvr,
  output logic        op32,
  output logic        addr32,
  output logic [15:0] opcode,
  output logic        twoByte,
  output logic        hasModrm,
  output logic [7:0]  modrm,
  output logic        hasSib,
  output logic [7:0]  sib,
  output logic [31:0] disp,
  output logic [31:0] imm
);
  always_ff @(posedge clk) begin
    if (!rstN || stb.clr) begin
      lock <= 1'b0; repNe <= 1'b0; rep <= 1'b0; segValid <= 1'b0; segCode <= 3'd0;
      opSzOvr <= 1'b0; adSzOvr <= 1'b0; opcode <= 16'h0; twoByte <= 1'b0;
      hasModrm <= 1'b0; modrm <= 8'h0; hasSib <= 1'b0; sib <= 8'h0;
      disp <= 32'h0; imm <= 32'h0;
    end
    if (rstN) begin
      if (stb.ldPfx) begin
        case (inByte)
          8'hF0: lock    <= 1'b1;
          8'hF2: repNe   <= 1'b1;
          8'hF3: rep     <= 1'b1;
          8'h66: opSzOvr <= 1'b1;
          8'h67: adSzOvr <= 1'b1;
          8'h26: begin segValid <= 1'b1; segCode <= 3'd0; end
          8'h2E: begin segValid <= 1'b1; segCode <= 3'd1; end
          8'h36: begin segValid <= 1'b1; segCode <= 3'd2; end
          8'h3E: begin segValid <= 1'b1; segCode <= 3'd3; end
          8'h64: begin segValid <= 1'b1; segCode <= 3'd4; end
          8'h65: begin segValid <= 1'b1; segCode <= 3'd5; end
          default: ;
        endcase
      end
      if (stb.ldOp1) begin
        opcode  <= {8'h00, inByte};
        twoByte <= 1'b0;
      end
      if (stb.ldOp2) begin
        opcode  <= {8'h0F, inByte};
        twoByte <= 1'b1;
      end
      if (stb.ldModrm) begin
        modrm    <= inByte;
        hasModrm <= 1'b1;
      end
      if (stb.ldSib) begin
        sib    <= inByte;
        hasSib <= 1'b1;
      end
      if (stb.ldDisp) disp[stb.idx*8 +: 8] <= inByte;
      if (stb.ldImm)  imm[stb.idx*8 +: 8]  <= inByte;
    end
  end

  assign op32   = mode32 ^ opSzOvr;
  assign addr32 = mode32 ^ adSzOvr;

  p_clear_on_start_r14: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (!hasModrm && !hasSib && disp == 32'h0 && imm == 32'h0));
  p_sib_needs_addr32_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldSib |-> addr32);
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.ldPfx, stb.ldOp1, stb.ldOp2, stb.ldModrm, stb.ldSib, stb.ldDisp, stb.ldImm}) <= 1);
endmodule

// File: rtl/insnFieldParser.sv
module insnFieldParser
  import ifp_pkg::*;
#(
  parameter int MAX_PREFIX = 4,
  localparam int LEN_W     = $clog2(MAX_PREFIX + 13)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  output logic             inReady,
  input  logic             mode32,
  output logic             outDone,
  output logic             outError,
  output logic [LEN_W-1:0] outLen,
  output logic             outLock,
  output logic             outRepNe,
  output logic             outRep,
  output logic             outSegValid,
  output logic [2:0]       outSegCode,
  output logic             outOpSzOvr,
  output logic             outAdSzOvr,
  output logic             outOp32,
  output logic             outAddr32,
  output logic [15:0]      outOpcode,
  output logic             outTwoByte,
  output logic             outHasModrm,
  output logic [1:0]       outMod,
  output logic [2:0]       outReg,
  output logic [2:0]       outRm,
  output logic             outHasSib,
  output logic [1:0]       outScale,
  output logic [2:0]       outIndex,
  output logic [2:0]       outBase,
  output logic [31:0]      outDisp,
  output logic [31:0]      outImm
);
  strobe_t    stb;
  logic [7:0] modrmByte, sibByte;

  ifpControl #(.MAX_PREFIX(MAX_PREFIX), .LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .mode32(mode32),
    .opSzOvr(outOpSzOvr), .adSzOvr(outAdSzOvr), .inReady(inReady), .stb(stb),
    .outDone(outDone), .outError(outError), .outLen(outLen)
  );

  ifpDatapath dp (
    .clk(clk), .rstN(rstN), .mode32(mode32), .stb(stb), .inByte(inByte),
    .lock(outLock), .repNe(outRepNe), .rep(outRep), .segValid(outSegValid),
    .segCode(outSegCode), .opSzOvr(outOpSzOvr), .adSzOvr(outAdSzOvr),
    .op32(outOp32), .addr32(outAddr32), .opcode(outOpcode), .twoByte(outTwoByte),
    .hasModrm(outHasModrm), .modrm(modrmByte), .hasSib(outHasSib), .sib(sibByte),
    .disp(outDisp), .imm(outImm)
  );

  assign outMod   = modrmByte[7:6];
  assign outReg   = modrmByte[5:3];
  assign outRm    = modrmByte[2:0];
  assign outScale = sibByte[7:6];
  assign outIndex = sibByte[5:3];
  assign outBase  = sibByte[2:0];
endmodule

// File: tb/insnFieldParser_test.sv
module insnFieldParser_test;
  logic        clk = 1'b0, rstN = 1'b0, inValid = 1'b0, mode32 = 1'b0;
  logic [7:0]  inByte = 8'h0;
  logic        inReady, outDone, outError, outLock, outRepNe, outRep, outSegValid;
  logic [4:0]  outLen;
  logic [2:0]  outSegCode, outReg, outRm, outIndex, outBase;
  logic        outOpSzOvr, outAdSzOvr, outOp32, outAddr32, outTwoByte, outHasModrm, outHasSib;
  logic [15:0] outOpcode;
  logic [1:0]  outMod, outScale;
  logic [31:0] outDisp, outImm;

  insnFieldParser uut (.*);

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [7:0] bytes [16];
  int nb;
  logic eErr, eLock, eRepNe, eRep, eSegV, eOpOv, eAdOv, eTwo, eHasM, eHasS;
  logic [2:0] eSeg;
  logic [15:0] eOpcode;
  logic [7:0] eModrm, eSib;
  logic [31:0] eDisp, eImm;
  int eLen;

  // {opcode16, needs operand byte, imm kind: 0 none, 1 byte, 2 word}
  localparam logic [19:0] OPTAB [21] = '{
    {16'h0001,1'b1,3'd0}, {16'h0004,1'b0,3'd1}, {16'h0005,1'b0,3'd2}, {16'h0050,1'b0,3'd0},
    {16'h0068,1'b0,3'd2}, {16'h006A,1'b0,3'd1}, {16'h0074,1'b0,3'd1}, {16'h0080,1'b1,3'd1},
    {16'h0081,1'b1,3'd2}, {16'h0083,1'b1,3'd1}, {16'h008B,1'b1,3'd0}, {16'h008D,1'b1,3'd0},
    {16'h00B3,1'b0,3'd1}, {16'h00BA,1'b0,3'd2}, {16'h00C7,1'b1,3'd2}, {16'h00E8,1'b0,3'd2},
    {16'h00EB,1'b0,3'd1}, {16'h0090,1'b0,3'd0}, {16'h0F84,1'b0,3'd2}, {16'h0FAF,1'b1,3'd0},
    {16'h0FB6,1'b1,3'd0}};
  localparam logic [7:0] PFXTAB [11] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                                          8'h26, 8'h64, 8'h65, 8'h66, 8'h67};

  task automatic chk(input string ctx, input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic clrExp();
    {eErr, eLock, eRepNe, eRep, eSegV, eOpOv, eAdOv, eTwo, eHasM, eHasS} = '0;
    eSeg = 0; eOpcode = 0; eModrm = 0; eSib = 0; eDisp = 0; eImm = 0; nb = 0;
  endtask

  task automatic push(input logic [7:0] b);
    bytes[nb] = b;
    nb++;
  endtask

  function automatic logic [31:0] lenMask(input int l);
    return (l >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * l)) - 32'd1);
  endfunction

  task automatic checkAll(input string ctx);
    chk(ctx, "R1 done", 32'(outDone), 32'd1);
    chk(ctx, "R5 error", 32'(outError), 32'(eErr));
    chk(ctx, "R13 length", 32'(outLen), 32'(eLen));
    chk(ctx, "R2 flags", {26'd0, outLock, outRepNe, outRep, outSegValid, outOpSzOvr, outAdSzOvr},
        {26'd0, eLock, eRepNe, eRep, eSegV, eOpOv, eAdOv});
    if (eSegV) chk(ctx, "R2 segment", 32'(outSegCode), 32'(eSeg));
    chk(ctx, "R12 sizes", {30'd0, outOp32, outAddr32}, {30'd0, mode32 ^ eOpOv, mode32 ^ eAdOv});
    chk(ctx, "R4 opcode", {15'd0, outTwoByte, outOpcode}, {15'd0, eTwo, eOpcode});
    chk(ctx, "R6 modrm", {23'd0, outHasModrm, outMod, outReg, outRm}, {23'd0, eHasM, eModrm});
    chk(ctx, "R7 sib", {23'd0, outHasSib, outScale, outIndex, outBase}, {23'd0, eHasS, eSib});
    chk(ctx, "R10 displacement", outDisp, eDisp);
    chk(ctx, "R11 immediate", outImm, eImm);
  endtask

  task automatic runInsn(input string ctx, input logic m32, input bit gaps);
    mode32 = m32;
    for (int i = 0; i < nb; i++) begin
      if (gaps) repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
      inByte = bytes[i]; inValid = 1'b1;
      @(posedge clk); #1;
      inValid = 1'b0;
      if (i < nb - 1) chk(ctx, "R1 early done", 32'(outDone), 32'd0);
    end
    eLen = nb;
    checkAll(ctx);
    vectors++;
  endtask

  task automatic genRandom(input logic m32);
    logic [19:0] e;
    logic [7:0]  b, s, p;
    logic [31:0] v;
    logic        a32, o32, hasSib;
    int np, dl, il;
    clrExp();
    np = $urandom_range(0, 4);
    for (int i = 0; i < np; i++) begin
      p = PFXTAB[$urandom_range(0, 10)];
      push(p);
      case (p)
        8'hF0: eLock = 1; 8'hF2: eRepNe = 1; 8'hF3: eRep = 1;
        8'h66: eOpOv = 1; 8'h67: eAdOv = 1;
        8'h26: begin eSegV = 1; eSeg = 0; end
        8'h2E: begin eSegV = 1; eSeg = 1; end
        8'h36: begin eSegV = 1; eSeg = 2; end
        8'h3E: begin eSegV = 1; eSeg = 3; end
        8'h64: begin eSegV = 1; eSeg = 4; end
        default: begin eSegV = 1; eSeg = 5; end
      endcase
    end
    e = OPTAB[$urandom_range(0, 20)];
    eOpcode = e[19:4];
    eTwo = (e[19:12] == 8'h0F);
    if (eTwo) push(8'h0F);
    push(e[11:4]);
    eHasM = e[3];
    a32 = m32 ^ eAdOv;
    o32 = m32 ^ eOpOv;
    dl = 0;
    if (eHasM) begin
      b = 8'($urandom);
      push(b); eModrm = b;
      hasSib = a32 && b[2:0] == 3'b100 && b[7:6] != 2'b11;
      case (b[7:6])
        2'b01: dl = 1;
        2'b10: dl = a32 ? 4 : 2;
        2'b00: dl = (a32 && b[2:0] == 3'b101) ? 4 : (!a32 && b[2:0] == 3'b110) ? 2 : 0;
        default: dl = 0;
      endcase
      if (hasSib) begin
        s = 8'($urandom);
        push(s); eSib = s; eHasS = 1;
        if (b[7:6] == 2'b00 && s[2:0] == 3'b101) dl = 4;
      end
    end
    v = $urandom;
    for (int k = 0; k < dl; k++) push(v[8*k +: 8]);
    eDisp = (dl == 0) ? 32'd0 : (v & lenMask(dl));
    il = (e[2:0] == 3'd1) ? 1 : (e[2:0] == 3'd2) ? (o32 ? 4 : 2) : 0;
    v = $urandom;
    for (int k = 0; k < il; k++) push(v[8*k +: 8]);
    eImm = (il == 0) ? 32'd0 : (v & lenMask(il));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    chk("reset", "R1 ready", 32'(inReady), 32'd1);
    chk("reset", "R1 no done", 32'(outDone), 32'd0);
    vectors++;

    // R8 R12: 32-bit memory form reached from 16-bit mode via both overrides
    clrExp(); eOpOv = 1; eAdOv = 1; eOpcode = 16'h008B; eHasM = 1; eModrm = 8'h9C;
    eHasS = 1; eSib = 8'h40; eDisp = 32'd1000;
    push(8'h67); push(8'h66); push(8'h8B); push(8'h9C); push(8'h40);
    push(8'hE8); push(8'h03); push(8'h00); push(8'h00);
    runInsn("R8 overrides example", 1'b0, 1'b0);

    // R3: fifth prefix
    clrExp(); eErr = 1; eOpOv = 1;
    for (int i = 0; i < 5; i++) push(8'h66);
    runInsn("R3 fifth prefix", 1'b1, 1'b0);

    // R5: unknown one-byte and two-byte opcodes
    clrExp(); eErr = 1; eOpcode = 16'h00D8; push(8'hD8);
    runInsn("R5 unknown one-byte", 1'b1, 1'b0);
    clrExp(); eErr = 1; eOpcode = 16'h0F05; eTwo = 1; push(8'h0F); push(8'h05);
    runInsn("R5 unknown two-byte", 1'b1, 1'b0);

    // R8: mod00 special displacement forms
    clrExp(); eOpcode = 16'h008B; eHasM = 1; eModrm = 8'h06; eDisp = 32'h1234;
    push(8'h8B); push(8'h06); push(8'h34); push(8'h12);
    runInsn("R8 16-bit direct", 1'b0, 1'b0);
    clrExp(); eOpcode = 16'h008B; eHasM = 1; eModrm = 8'h05; eDisp = 32'h12345678;
    push(8'h8B); push(8'h05); push(8'h78); push(8'h56); push(8'h34); push(8'h12);
    runInsn("R8 32-bit direct", 1'b1, 1'b0);

    // R9: SIB base 101 with mod00
    clrExp(); eOpcode = 16'h008B; eHasM = 1; eModrm = 8'h04; eHasS = 1; eSib = 8'h25;
    eDisp = 32'hCAFEF00D;
    push(8'h8B); push(8'h04); push(8'h25); push(8'h0D); push(8'hF0); push(8'hFE); push(8'hCA);
    runInsn("R9 sib base disp32", 1'b1, 1'b0);

    // R7: r/m 100 at 16-bit address size takes no SIB
    clrExp(); eOpcode = 16'h008B; eHasM = 1; eModrm = 8'h04; push(8'h8B); push(8'h04);
    runInsn("R7 no sib in 16-bit", 1'b0, 1'b0);

    // R11: word immediate sized by operand size
    clrExp(); eOpOv = 1; eOpcode = 16'h00B8; eImm = 32'h1234;
    push(8'h66); push(8'hB8); push(8'h34); push(8'h12);
    runInsn("R11 imm16 in 32-bit", 1'b1, 1'b0);
    clrExp(); eOpOv = 1; eOpcode = 16'h00B8; eImm = 32'h89ABCDEF;
    push(8'h66); push(8'hB8); push(8'hEF); push(8'hCD); push(8'hAB); push(8'h89);
    runInsn("R11 imm32 in 16-bit", 1'b0, 1'b0);

    // R14: back-to-back single-byte instructions, fields restart
    clrExp(); eOpcode = 16'h0090; push(8'h90);
    runInsn("R14 first", 1'b1, 1'b0);
    runInsn("R14 second", 1'b1, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic m;
      m = 1'($urandom);
      genRandom(m);
      runInsn("random", m, n % 2 == 1);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule